// File: doc/BRIEF.md
# Effective Address Sequencer for an 8-bit Accumulator Machine

This block turns an addressing-mode code, the one or two operand bytes of an instruction and the two index registers into the 16-bit effective address that the later data access will use. Modes that need no memory access (page zero, page zero plus an index, a full address, a full address plus an index, and a direct jump target) complete from the inputs alone. Modes that go through a stored pointer fetch two bytes through a byte-wide read port with a request/valid handshake, put them together and, where the mode asks for it, add an index afterwards.

The two pointer-based data modes apply the index at opposite ends of the walk. In the pre-X form the operand plus X selects a pointer slot in page zero and the pointer read there is the result. In the post-Y form the operand names the pointer slot directly and Y is added to the 16-bit pointer. Every sum that is meant to stay in page zero wraps at 256, including the step from a pointer's low byte to its high byte. The caller presents a mode with a one-cycle `start` while the block is idle and waits for the one-cycle `done` strobe, at which point `eff_addr` is valid and stays put until the next result.

Top module: `addr_mode_unit`

## Requirements
- R1: After a synchronous reset `busy`, `done` and `rd_req` are low and `eff_addr` is zero.
- R2: Codes 0 (page zero), 1 (page zero plus X) and 2 (page zero plus Y, meant for the X-register load/store path) give high byte zero and low byte `opnd_lo`, `opnd_lo+idx_x` or `opnd_lo+idx_y`, each sum modulo 256.
- R3: Codes 3 (full address), 4 (full plus X) and 5 (full plus Y) give `{opnd_hi,opnd_lo}`, plus the zero-extended index for 4 and 5, carrying into the high byte and wrapping modulo 65536.
- R4: Code 6 (pre-X pointer) reads page-zero locations P=(opnd_lo+idx_x) mod 256 and (P+1) mod 256 and returns the 16-bit pointer found there.
- R5: Code 7 (post-Y pointer) reads page-zero locations opnd_lo and (opnd_lo+1) mod 256 and returns that pointer plus zero-extended `idx_y`, modulo 65536.
- R6: Code 8 (jump through pointer) reads A={opnd_hi,opnd_lo} and (A+1) mod 65536 and returns the pointer; code 9 (direct jump) returns `{opnd_hi,opnd_lo}` without a memory read.
- R7: A pointer is assembled low byte first: the first address read supplies bits 7:0 and the second bits 15:8; in codes 6 and 7 a slot at 0xFF takes its high byte from 0x00.
- R8: At most one read is outstanding; `rd_req` and `rd_addr` hold until a cycle with `rd_valid` high, and `rd_valid` while `rd_req` is low has no effect.
- R9: `done` pulses one cycle per result with `rd_req` low; for codes 0-5 and 9 it is high in the cycle right after the cycle that accepted `start`.
- R10: `start` is accepted only when `busy` is low; a `start` during a pointer fetch leaves the running result unchanged.
- R11: With `idx_x` and `idx_y` both zero, codes 6 and 7 give the same address for the same operand.
- R12: Codes 10 to 15 behave like code 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (taken only while not busy) |
| mode | input | 4 | Addressing-mode code |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| rd_req | output | 1 | Read request, held until accepted |
| rd_addr | output | 16 | Read address |
| rd_valid | input | 1 | Read data valid, consumed while `rd_req` is high |
| rd_data | input | 8 | Read data byte |
| busy | output | 1 | A pointer fetch is in progress |
| done | output | 1 | One-cycle strobe: `eff_addr` holds a new result |
| eff_addr | output | 16 | Effective address |

## Verification
Every mode code is swept over operand bytes at the page edges (0x00, 0x01, 0x7F, 0x80, 0xFE, 0xFF), high bytes 0x00, 0x12 and 0xFF, and index values 0, 1, 0x80 and 0xFF, so that page-zero wrap, carry into the high byte and 16-bit wrap are each separated from plain addition. Pointer slots at 0xFF tell a page-zero wrap of the second fetch from a carry into page one, and a memory model whose byte depends on both address bytes tells the fetch order and byte placement apart. Read latency varies from zero to two wait cycles, and targeted cases cover a stray `rd_valid`, a `start` during a fetch, a reset in the middle of a fetch and the X=Y=0 match of the two pointer modes.

// File: rtl/amu_pkg.sv
package amu_pkg;

  typedef enum logic [3:0] {
    MODE_PAGE0        = 4'd0,
    MODE_PAGE0_X      = 4'd1,
    MODE_PAGE0_Y      = 4'd2,
    MODE_FULL         = 4'd3,
    MODE_FULL_X       = 4'd4,
    MODE_FULL_Y       = 4'd5,
    MODE_PTR_PRE_X    = 4'd6,
    MODE_PTR_POST_Y   = 4'd7,
    MODE_JMP_PTR      = 4'd8,
    MODE_JMP_FULL     = 4'd9
  } amu_mode_e;

  function automatic logic is_page0_mode(input logic [3:0] m);
    return (m == MODE_PAGE0) || (m == MODE_PAGE0_X) || (m == MODE_PAGE0_Y);
  endfunction

endpackage

// File: rtl/amu_mode_decode.sv
module amu_mode_decode
  import amu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]      mode_i,
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  output logic [2*DW-1:0] direct_ea_o,
  output logic            fetch_o,
  output logic [2*DW-1:0] fetch_base_o,
  output logic            fetch_wrap_o,
  output logic [DW-1:0]   post_add_o
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] ZERO_PAGE = '0;

  logic [AW-1:0] full_addr;
  logic [DW-1:0] page0_x;
  logic [DW-1:0] page0_y;

  // page-zero sums drop the carry on purpose (R2, R4)
  assign full_addr = {hi_i, lo_i};
  assign page0_x   = lo_i + x_i;
  assign page0_y   = lo_i + y_i;

  always_comb begin
    direct_ea_o  = full_addr;
    fetch_o      = 1'b0;
    fetch_base_o = full_addr;
    fetch_wrap_o = 1'b0;
    post_add_o   = '0;
    case (mode_i)
      MODE_PAGE0:   direct_ea_o = {ZERO_PAGE, lo_i};
      MODE_PAGE0_X: direct_ea_o = {ZERO_PAGE, page0_x};
      MODE_PAGE0_Y: direct_ea_o = {ZERO_PAGE, page0_y};
      MODE_FULL_X:  direct_ea_o = full_addr + AW'(x_i);
      MODE_FULL_Y:  direct_ea_o = full_addr + AW'(y_i);
      MODE_PTR_PRE_X: begin
        fetch_o      = 1'b1;
        fetch_base_o = {ZERO_PAGE, page0_x};
        fetch_wrap_o = 1'b1;
      end
      MODE_PTR_POST_Y: begin
        fetch_o      = 1'b1;
        fetch_base_o = {ZERO_PAGE, lo_i};
        fetch_wrap_o = 1'b1;
        post_add_o   = y_i;
      end
      MODE_JMP_PTR: begin
        fetch_o      = 1'b1;
        fetch_base_o = full_addr;
      end
      // MODE_FULL, MODE_JMP_FULL and unused codes (R12) keep the operand
      default: direct_ea_o = full_addr;
    endcase
  end

endmodule

// File: rtl/amu_ptr_fetch.sv
module amu_ptr_fetch #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_i,
  input  logic [2*DW-1:0] base_i,
  input  logic            wrap_i,
  output logic            rd_req_o,
  output logic [2*DW-1:0] rd_addr_o,
  input  logic            rd_valid_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            ptr_ready_o,
  output logic [2*DW-1:0] ptr_o
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] ZERO_PAGE = '0;

  typedef enum logic [1:0] {F_IDLE, F_LOW, F_HIGH} fetch_state_e;

  fetch_state_e  state_q;
  logic [AW-1:0] second_q;
  logic [DW-1:0] low_q;
  logic [DW-1:0] base_inc_page;
  logic [AW-1:0] second_addr;

  // second byte address: wraps in page zero or steps through all 16 bits (R7, R6)
  assign base_inc_page = base_i[DW-1:0] + 1'b1;
  assign second_addr   = wrap_i ? {ZERO_PAGE, base_inc_page} : base_i + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= F_IDLE;
      rd_req_o    <= 1'b0;
      rd_addr_o   <= '0;
      second_q    <= '0;
      low_q       <= '0;
      ptr_ready_o <= 1'b0;
      ptr_o       <= '0;
    end else begin
      ptr_ready_o <= 1'b0;
      case (state_q)
        F_IDLE: begin
          if (go_i) begin
            rd_req_o  <= 1'b1;
            rd_addr_o <= base_i;
            second_q  <= second_addr;
            state_q   <= F_LOW;
          end
        end
        F_LOW: begin
          if (rd_valid_i) begin
            low_q     <= rd_data_i;
            rd_addr_o <= second_q;
            state_q   <= F_HIGH;
          end
        end
        F_HIGH: begin
          if (rd_valid_i) begin
            ptr_o       <= {rd_data_i, low_q};
            rd_req_o    <= 1'b0;
            ptr_ready_o <= 1'b1;
            state_q     <= F_IDLE;
          end
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end

  // R8: an unanswered request keeps its address
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R9: the pointer-ready pulse lasts one cycle
  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    ptr_ready_o |=> !ptr_ready_o);

  // R8: ready only once the request is gone
  assert_ready_noreq_R8: assert property (@(posedge clk) disable iff (rst)
    ptr_ready_o |-> !rd_req_o);

endmodule

// File: rtl/addr_mode_unit.sv
module addr_mode_unit
  import amu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [DW-1:0] opnd_lo,
  input  logic [DW-1:0] opnd_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] eff_addr
);
  logic [AW-1:0] direct_ea;
  logic          need_fetch;
  logic [AW-1:0] fetch_base;
  logic          fetch_wrap;
  logic [DW-1:0] post_add;
  logic          accept;
  logic          fetch_go;
  logic          ptr_ready;
  logic [AW-1:0] ptr_val;
  logic          wait_q;
  logic [DW-1:0] post_q;
  logic [3:0]    mode_q;

  assign accept   = start && !wait_q;   // R10
  assign fetch_go = accept && need_fetch;
  assign busy     = wait_q;

  amu_mode_decode #(.DW(DW)) u_decode (
    .mode_i       (mode),
    .lo_i         (opnd_lo),
    .hi_i         (opnd_hi),
    .x_i          (idx_x),
    .y_i          (idx_y),
    .direct_ea_o  (direct_ea),
    .fetch_o      (need_fetch),
    .fetch_base_o (fetch_base),
    .fetch_wrap_o (fetch_wrap),
    .post_add_o   (post_add)
  );

  amu_ptr_fetch #(.DW(DW)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .go_i        (fetch_go),
    .base_i      (fetch_base),
    .wrap_i      (fetch_wrap),
    .rd_req_o    (rd_req),
    .rd_addr_o   (rd_addr),
    .rd_valid_i  (rd_valid),
    .rd_data_i   (rd_data),
    .ptr_ready_o (ptr_ready),
    .ptr_o       (ptr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q   <= 1'b0;
      done     <= 1'b0;
      eff_addr <= '0;
      post_q   <= '0;
      mode_q   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        mode_q <= mode;
        if (need_fetch) begin
          wait_q <= 1'b1;
          post_q <= post_add;
        end else begin
          eff_addr <= direct_ea;
          done     <= 1'b1;
        end
      end
      if (ptr_ready) begin
        eff_addr <= ptr_val + AW'(post_q);   // R5 post-index
        done     <= 1'b1;
        wait_q   <= 1'b0;
      end
    end
  end

  // R9: direct modes finish in the next cycle without a read
  assert_direct_done_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && !need_fetch) |=> (done && !rd_req));

  // R2: page-zero results never leave page zero
  assert_page0_high_R2: assert property (@(posedge clk) disable iff (rst)
    (done && is_page0_mode(mode_q)) |-> (eff_addr[AW-1:DW] == '0));

  // R8: reads only happen inside a busy window
  assert_req_busy_R8: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  // R9: the strobe never overlaps a pending read
  assert_done_noreq_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_req);

  // R10: a start during a fetch does not disturb the latched post-index
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(post_q));

endmodule

// File: tb/addr_mode_unit_bench.sv
`timescale 1ns/1ps
module addr_mode_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = '0;
  logic        busy, done;
  logic [15:0] eff_addr;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  int reads  = 0;
  bit resp_en = 1'b1;

  always #2.5 clk = ~clk;

  addr_mode_unit u_addr_mode_unit (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .eff_addr(eff_addr)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd29;
    return t ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] expect_ea(input logic [3:0] m, input logic [7:0] lo,
      input logic [7:0] hi, input logic [7:0] x, input logic [7:0] y);
    logic [7:0]  p;
    logic [15:0] a;
    case (m)
      4'd0: return {8'h00, lo};
      4'd1: return {8'h00, 8'(lo + x)};
      4'd2: return {8'h00, 8'(lo + y)};
      4'd4: return 16'({hi, lo} + {8'h00, x});
      4'd5: return 16'({hi, lo} + {8'h00, y});
      4'd6: begin
        p = lo + x;
        return {mem_byte({8'h00, 8'(p + 8'd1)}), mem_byte({8'h00, p})};
      end
      4'd7: begin
        p = lo;
        return 16'({mem_byte({8'h00, 8'(p + 8'd1)}), mem_byte({8'h00, p})} + {8'h00, y});
      end
      4'd8: begin
        a = {hi, lo};
        return {mem_byte(16'(a + 16'd1)), mem_byte(a)};
      end
      default: return {hi, lo};
    endcase
  endfunction

  // memory responder: answers a held request after lat wait cycles
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_valid <= 1'b0;
      wcnt     <= 0;
    end else if (rd_req && resp_en) begin
      if (wcnt >= lat) begin
        rd_valid <= 1'b1;
        rd_data  <= mem_byte(rd_addr);
        reads    <= reads + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_for(input logic [3:0] m);
    case (m)
      4'd0, 4'd1, 4'd2: return "R2";
      4'd3, 4'd4, 4'd5: return "R3";
      4'd6: return "R4";
      4'd7: return "R5";
      4'd8, 4'd9: return "R6";
      default: return "R12";
    endcase
  endfunction

  // runs one computation; returns the result seen with done
  task automatic run(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                     input logic [7:0] x, input logic [7:0] y, output logic [15:0] res);
    int n;
    int r0;
    bit direct;
    direct = !(m == 4'd6 || m == 4'd7 || m == 4'd8);
    @(negedge clk);
    mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; start = 1'b1;
    r0 = reads;
    @(negedge clk);
    start = 1'b0;
    if (direct) begin
      // R9: direct result one cycle after acceptance, no read
      check(done === 1'b1 && rd_req === 1'b0, "R9", {30'd0, done, rd_req}, 32'h2);
    end
    n = 0;
    while (done !== 1'b1 && n < 40) begin
      @(negedge clk);
      n++;
    end
    res = eff_addr;
    check(done === 1'b1, "R9", {31'd0, done}, 32'd1);
    if (direct)
      check(reads == r0, "R6", reads - r0, 0);
    else
      check(reads == r0 + 2, "R8", reads - r0, 2);
    @(negedge clk);
    check(done === 1'b0, "R9", {31'd0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] res, exp, r6, r7;
    logic [7:0] los [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    logic [7:0] his [3] = '{8'h00, 8'h12, 8'hFF};
    logic [7:0] idxs[4] = '{8'h00, 8'h01, 8'h80, 8'hFF};
    int k;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(busy === 1'b0 && done === 1'b0 && rd_req === 1'b0, "R1",
          {29'd0, busy, done, rd_req}, 32'd0);
    check(eff_addr === 16'h0000, "R1", eff_addr, 0);

    // sweep all codes over edge operands and index values
    k = 0;
    for (int m = 0; m < 16; m++) begin
      for (int a = 0; a < 6; a++) begin
        for (int b = 0; b < 3; b++) begin
          for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
              if (m < 10 || (i == j && b == 1)) begin
                lat = k % 3;
                k++;
                run(4'(m), los[a], his[b], idxs[i], idxs[j], res);
                exp = expect_ea(4'(m), los[a], his[b], idxs[i], idxs[j]);
                check(res === exp, tag_for(4'(m)), res, exp);
              end
            end
          end
        end
      end
    end

    // R7: pointer slot 0xFF takes its high byte from 0x00
    lat = 1;
    run(4'd7, 8'hFF, 8'h00, 8'h00, 8'h00, res);
    exp = {mem_byte(16'h0000), mem_byte(16'h00FF)};
    check(res === exp, "R7", res, exp);
    run(4'd6, 8'hFE, 8'h00, 8'h01, 8'h00, res);
    check(res === exp, "R7", res, exp);

    // R11: X=Y=0 makes both pointer modes agree
    for (int a = 0; a < 6; a++) begin
      run(4'd6, los[a], 8'h00, 8'h00, 8'h00, r6);
      run(4'd7, los[a], 8'h00, 8'h00, 8'h00, r7);
      check(r6 === r7, "R11", r6, r7);
    end

    // R8: request held with stable address while unanswered; stray valid ignored
    resp_en = 1'b0;
    @(negedge clk);
    rd_valid = 1'b1; rd_data = 8'hEE;   // stray valid while idle
    @(negedge clk);
    rd_valid = 1'b0;
    check(rd_req === 1'b0 && done === 1'b0, "R8", {30'd0, rd_req, done}, 0);
    mode = 4'd6; opnd_lo = 8'h40; idx_x = 8'h02; idx_y = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(rd_req === 1'b1 && rd_addr === 16'h0042, "R8", rd_addr, 16'h0042);
    repeat (4) @(negedge clk);
    check(rd_req === 1'b1 && rd_addr === 16'h0042 && busy === 1'b1, "R8", rd_addr, 16'h0042);
    // R10: start while busy ignored
    mode = 4'd3; opnd_lo = 8'h34; opnd_hi = 8'h12; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b0 && rd_addr === 16'h0042, "R10", rd_addr, 16'h0042);
    resp_en = 1'b1;
    k = 0;
    while (done !== 1'b1 && k < 40) begin
      @(negedge clk);
      k++;
    end
    exp = expect_ea(4'd6, 8'h40, 8'h00, 8'h02, 8'h00);
    check(eff_addr === exp && done === 1'b1, "R10", eff_addr, exp);

    // R1: reset in the middle of a fetch returns to idle
    resp_en = 1'b0;
    @(negedge clk);
    mode = 4'd8; opnd_lo = 8'h00; opnd_hi = 8'h30; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && rd_req === 1'b0 && done === 1'b0, "R1",
          {29'd0, busy, rd_req, done}, 0);
    resp_en = 1'b1;
    run(4'd8, 8'hFF, 8'h30, 8'h00, 8'h00, res);
    exp = {mem_byte(16'h3100), mem_byte(16'h30FF)};
    check(res === exp, "R6", res, exp);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule